// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial EEPROM. It watches the clock and data lines of the bus through the system clock and recognises start and stop conditions. After every start condition the first byte is a selection byte. That byte either opens a write, where an address byte and any number of data bytes follow, or a read, where the block streams bytes out of its storage array for as long as the master acknowledges them.

The storage array holds 128 or 256 bytes, set by a parameter. One address counter serves both directions. An address byte loads it. Each stored byte and each byte handed out advances it. This gives current-address reads, sequential reads, and random reads made from a write preamble followed by a repeated start. The data line is modelled as an open-drain pull-down enable. The line's actual level comes back on a separate input.

Top module: `twiEepromSlave`

## Requirements
- R1: The block acknowledges a selection byte only when its bits 7..4 equal 1010. Any other selection byte gets no acknowledge, and the block then acknowledges nothing, and stores nothing, until the next start condition.
- R2: Bits 3..1 of the selection byte are don't-care: every combination gets the same response.
- R3: Bit 0 of the selection byte chooses the direction: 0 opens a write and 1 opens a read.
- R4: In a write, the byte after the selection byte is acknowledged and loads the address counter with its low log2(depth) bits. In the 128-byte variant, bit 7 is ignored.
- R5: Each data byte after the address byte is acknowledged, stored at once at the counter's address, and the counter advances by one.
- R6: In a read, the block sends the byte at the counter's address MSB first and advances the counter. It sends another byte after every byte the master acknowledges (data low in the ninth clock), and stops after a byte the master leaves unacknowledged.
- R7: The address counter wraps from the top address to 0, in both writes and reads.
- R8: A read that follows a write or a read without a new address byte starts at the address after the last byte written or read.
- R9: The pull-down enable is inactive after reset and changes only while the clock line is low.
- R10: A start or stop condition in the middle of a byte abandons that byte without storing it. A start during a transfer acts as a repeated start and waits for a new selection byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level, as seen on the wire |
| sdaPullDown | output | 1 | When high, the block pulls the data line low |

## Verification
The hardest situations to reach are the counter wrapping in the middle of a sequential read, and a byte cut short by a stop or by a repeated start. Neither can be set up directly: the counter has no load path other than the bus. The stimulus therefore first fills the whole array through one long write whose counter wraps to zero. It then reads across the top address, and it drives partial bytes followed by bus conditions. A reference model of the array and the counter is updated alongside, so that seeded random writes and reads are checked against known contents.

// File: rtl/twiEepPkg.sv
package twiEepPkg;

  // Fixed upper nibble of the selection byte
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } busState_t;

  // Strobes from control to datapath, each one cycle wide
  typedef struct packed {
    logic shiftIn;   // take the sampled data bit into the receive register
    logic loadAddr;  // copy the received byte into the address counter
    logic writeMem;  // store the received byte and advance the counter
    logic loadTx;    // fetch the byte at the counter and advance the counter
    logic shiftTx;   // present the next transmit bit
  } dpStrobe_t;

endpackage

// File: rtl/twiEepCtrl.sv
module twiEepCtrl
  import twiEepPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  strb,
  output logic       sdaSample,
  output logic       stopSeen,
  output logic       sdaPullDown
);

  logic [1:0] sclSh, sdaSh;   // [0] newest sample
  logic       sclRise, sclFall, startSeen;
  busState_t  state;
  logic [3:0] bitCnt;         // 0..7 data bits, 8 byte done, 9 ack clock high
  logic       ackDrive, txEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh <= 2'b11;
      sdaSh <= 2'b11;
    end else begin
      sclSh <= {sclSh[0], sclIn};
      sdaSh <= {sdaSh[0], sdaIn};
    end
  end

  assign sclRise   = sclSh[0] & ~sclSh[1];
  assign sclFall   = ~sclSh[0] & sclSh[1];
  assign startSeen = sclSh[0] & sclSh[1] & sdaSh[1] & ~sdaSh[0];
  assign stopSeen  = sclSh[0] & sclSh[1] & ~sdaSh[1] & sdaSh[0];
  assign sdaSample = sdaSh[0];

  always_comb begin
    strb = '0;
    if (!startSeen && !stopSeen && state != ST_IDLE) begin
      if (sclRise && bitCnt < 4'd8) strb.shiftIn = 1'b1;
      if (sclFall && bitCnt == 4'd8) begin
        strb.loadAddr = (state == ST_ADDR);
        strb.writeMem = (state == ST_WDATA);
      end
      if (sclFall && bitCnt == 4'd9 && state == ST_RDATA) strb.loadTx = 1'b1;
      if (sclFall && state == ST_RDATA && txEn && bitCnt >= 4'd1 && bitCnt <= 4'd7)
        strb.shiftTx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
    end else if (startSeen) begin
      state    <= ST_CMD;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
    end else if (stopSeen) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (sclRise) begin
        if (bitCnt < 4'd8) begin
          bitCnt <= bitCnt + 4'd1;
        end else if (bitCnt == 4'd8) begin
          if (state == ST_RDATA && sdaSh[0]) begin
            state  <= ST_IDLE;       // master left the byte unacknowledged
            bitCnt <= '0;
          end else begin
            bitCnt <= 4'd9;
          end
        end
      end
      if (sclFall) begin
        if (bitCnt == 4'd8) begin
          unique case (state)
            ST_CMD: begin
              if (rxByte[7:4] == DEV_CODE) begin
                ackDrive <= 1'b1;
                state    <= rxByte[0] ? ST_RDATA : ST_ADDR;
              end else begin
                state  <= ST_IDLE;
                bitCnt <= '0;
              end
            end
            ST_ADDR: begin
              ackDrive <= 1'b1;
              state    <= ST_WDATA;
            end
            ST_WDATA: ackDrive <= 1'b1;
            ST_RDATA: txEn     <= 1'b0;
            default: ;
          endcase
        end else if (bitCnt == 4'd9) begin
          ackDrive <= 1'b0;
          bitCnt   <= '0;
          if (state == ST_RDATA) txEn <= 1'b1;
        end
      end
    end
  end

  assign sdaPullDown = ackDrive | (txEn & ~txBit);

endmodule

// File: rtl/twiEepData.sv
module twiEepData
  import twiEepPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              sdaSample,
  output logic [7:0]        rxByte,
  output logic [ADDR_W-1:0] addrPtr,
  output logic              txBit
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] memArr [DEPTH];
  logic [7:0] txReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      addrPtr <= '0;
      txReg   <= 8'hFF;
    end else begin
      if (strb.shiftIn)  rxByte  <= {rxByte[6:0], sdaSample};
      if (strb.loadAddr) addrPtr <= rxByte[ADDR_W-1:0];
      if (strb.writeMem || strb.loadTx) addrPtr <= addrPtr + 1'b1;
      if (strb.loadTx)   txReg   <= memArr[addrPtr];
      else if (strb.shiftTx) txReg <= {txReg[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (strb.writeMem) memArr[addrPtr] <= rxByte;
  end

  assign txBit = txReg[7];

endmodule

// File: rtl/twiEepromSlave.sv
module twiEepromSlave
  import twiEepPkg::*;
#(
  parameter int MEM_BYTES = 256
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullDown
);

  localparam int ADDR_W = $clog2(MEM_BYTES);

  dpStrobe_t         strb;
  logic              sdaSample, stopSeen, txBit;
  logic [7:0]        rxByte;
  logic [ADDR_W-1:0] addrPtr;

  twiEepCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txBit(txBit), .strb(strb),
    .sdaSample(sdaSample), .stopSeen(stopSeen), .sdaPullDown(sdaPullDown)
  );

  twiEepData #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaSample(sdaSample),
    .rxByte(rxByte), .addrPtr(addrPtr), .txBit(txBit)
  );

endmodule

// File: rtl/twiEepChk.sv
module twiEepChk
  import twiEepPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaPullDown,
  input logic              stopSeen,
  input dpStrobe_t         strb,
  input logic [7:0]        rxByte,
  input logic [ADDR_W-1:0] addrPtr
);

  // R9
  pull_hold_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaPullDown));

  // R4
  addr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadAddr |=> addrPtr == $past(rxByte[ADDR_W-1:0]));

  // R5
  write_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeMem |=> addrPtr == ADDR_W'($past(addrPtr) + 1'b1));

  // R6
  read_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTx |=> addrPtr == ADDR_W'($past(addrPtr) + 1'b1));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaPullDown);

endmodule

bind twiEepromSlave twiEepChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullDown(sdaPullDown),
  .stopSeen(stopSeen), .strb(strb), .rxByte(rxByte), .addrPtr(addrPtr)
);

// File: tb/twiEepromSlave_tb.sv
`timescale 1ns/1ps
module twiEepromSlave_tb;

  localparam int DEPTH = 128;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaPullDown;
  logic sdaBus;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [DEPTH];
  int ptr = 0;

  always #2 clk = ~clk;
  assign sdaBus = sdaDrv & ~sdaPullDown;

  twiEepromSlave #(.MEM_BYTES(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus), .sdaPullDown(sdaPullDown)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startCond();
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaDrv = b[i]; waitQ();
      sclDrv = 1'b1; waitQ(); waitQ();
      sclDrv = 1'b0; waitQ();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    acked = (sdaBus == 1'b0);
    waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    logic early;
    sdaDrv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      sclDrv = 1'b1; waitQ();
      early = sdaBus;
      waitQ();
      check(sdaBus == early, "R9 data held while clock high", sdaBus, early);
      b[i] = early;
      sclDrv = 1'b0;
    end
    waitQ();
    sdaDrv = ackIt ? 1'b0 : 1'b1; waitQ();
    sclDrv = 1'b1; waitQ(); waitQ();
    sclDrv = 1'b0; waitQ();
    sdaDrv = 1'b1;
  endtask

  function automatic logic [7:0] selByte(input bit rd);
    return {4'b1010, 3'($urandom), rd};
  endfunction

  task automatic writeTxn(input logic [7:0] addr, input int n);
    bit ak;
    logic [7:0] d;
    startCond();
    sendByte(selByte(1'b0), ak);
    check(ak, "R2 R3 write selection acknowledged", ak, 1);
    sendByte(addr, ak);
    check(ak, "R4 address byte acknowledged", ak, 1);
    ptr = addr % DEPTH;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      sendByte(d, ak);
      check(ak, "R5 data byte acknowledged", ak, 1);
      model[ptr] = d;
      ptr = (ptr + 1) % DEPTH;
    end
    stopCond();
  endtask

  task automatic readBytes(input int n, input string req);
    logic [7:0] got;
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, got);
      check(got == model[ptr], req, got, model[ptr]);
      ptr = (ptr + 1) % DEPTH;
    end
  endtask

  task automatic readCur(input int n, input string req);
    bit ak;
    startCond();
    sendByte(selByte(1'b1), ak);
    check(ak, "R3 read selection acknowledged", ak, 1);
    readBytes(n, req);
    stopCond();
  endtask

  task automatic readRand(input logic [7:0] addr, input int n, input string req);
    bit ak;
    startCond();
    sendByte(selByte(1'b0), ak);
    check(ak, "R2 write selection acknowledged", ak, 1);
    sendByte(addr, ak);
    check(ak, "R4 address byte acknowledged", ak, 1);
    ptr = addr % DEPTH;
    startCond();
    sendByte(selByte(1'b1), ak);
    check(ak, "R10 repeated start then read acknowledged", ak, 1);
    readBytes(n, req);
    stopCond();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ak;
    void'($urandom(32'h5EED1234));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(sdaPullDown == 1'b0, "R9 released after reset", sdaPullDown, 0);

    // Fill the whole array; the counter wraps back to 0 (R5, R7)
    writeTxn(8'h00, DEPTH);
    check(ptr == 0, "R7 model pointer wrapped", ptr, 0);
    readCur(3, "R7 R8 current read after wrapped write");

    // Address bit 7 ignored, read across the top (R4, R7, R6)
    readRand(8'hFE, 4, "R4 R7 sequential read across top");

    // Write then current-address read (R8)
    writeTxn(8'h30, 2);
    readCur(2, "R8 read continues after write");

    // Bad selection byte: no ack, later bytes ignored (R1)
    startCond();
    sendByte(8'hB6, ak);
    check(!ak, "R1 wrong nibble not acknowledged", ak, 0);
    sendByte(8'hA0, ak);
    check(!ak, "R1 ignored until start", ak, 0);
    sendByte(8'h40, ak);
    check(!ak, "R1 ignored until start", ak, 0);
    stopCond();
    readCur(1, "R1 pointer and array untouched");

    // Stop in mid byte abandons it (R10)
    startCond();
    sendByte(selByte(1'b0), ak);
    sendByte(8'h10, ak);
    ptr = 8'h10;
    sendBits(~model[8'h10], 4);
    stopCond();
    readCur(1, "R10 stop abandons partial byte");

    // Repeated start in mid byte (R10)
    startCond();
    sendByte(selByte(1'b0), ak);
    sendByte(8'h20, ak);
    ptr = 8'h20;
    sendBits(~model[8'h20], 3);
    startCond();
    sendByte(selByte(1'b1), ak);
    check(ak, "R10 read after mid-byte start acknowledged", ak, 1);
    readBytes(2, "R10 repeated start abandons partial byte");
    stopCond();

    // Seeded random mix (R2 R3 R5 R6)
    for (int t = 0; t < 15; t++) begin
      if ($urandom_range(0, 1) == 0)
        writeTxn(8'($urandom), int'($urandom_range(1, 4)));
      else if ($urandom_range(0, 1) == 0)
        readCur(int'($urandom_range(1, 4)), "R6 random current read");
      else
        readRand(8'($urandom), int'($urandom_range(1, 4)), "R6 random address read");
    end

    check(sdaPullDown == 1'b0, "R9 released at end", sdaPullDown, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule